// File: doc/BRIEF.md
# Per-Port Line Control and Status Register Bank

This block is a byte-wide register bank that a processor reaches through one chip-select strobe. It gathers the board-level status of four line ports (the backplane slot number, a per-port loss-of-sync flag and the state of each framer's timeslot-enable pin). It also holds four software-owned timing-mode bits, one per port.

Only address bits [3:2] choose a register. Bits [1:0] and every bit above bit 3 are ignored, so the three registers repeat across the whole chip-select window.

Each port also has one bidirectional clock/sync pin. When the external line-mode select of a port is high (network side), the block drives that pin with the port's stored timing-mode bit. When the select is low (terminal side, the default), the block releases the pin so the framer can use it as an input.

Top module: `board_csr`

## Requirements
- R1: After a synchronous reset, every timing-mode bit is 0, the read data output is 0 and no clock/sync pin is driven while its line-mode select is low.
- R2: A read with address bits [3:2] = 00 returns the 5-bit slot number in bits 4:0 on the cycle after the strobe; bits 7:5 read 0.
- R3: A read with address bits [3:2] = 01 returns the four loss-of-sync flags (port 4 in bit 7 down to port 1 in bit 4) and the four timing-mode bits (port 4 in bit 3 down to port 1 in bit 0).
- R4: A write with address bits [3:2] = 01 loads write-data bits 3:0 into the timing-mode bits at the clock edge of the strobe; write-data bits 7:4 are discarded.
- R5: A read with address bits [3:2] = 10 returns the four timeslot-enable pin states in bits 3:0 (port 4 in bit 3); bits 7:4 read 0.
- R6: A read with address bits [3:2] = 11 returns 0. Writes with address bits [3:2] equal to 00, 10 or 11 leave the timing-mode bits unchanged.
- R7: Address bits [1:0] and all address bits above bit 3 have no effect on which register is read or written (mirroring).
- R8: While a port's line-mode select is 1, its clock/sync pin is driven with that port's timing-mode bit. While the select is 0, the pin is left undriven, and the level placed on it from outside is seen on the pin unchanged.
- R9: The read data output changes only on a read strobe (chip-select high with write-enable low) and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip-select strobe, one access per cycle it is high |
| we | input | 1 | 1 = write access, 0 = read access |
| addr | input | 8 | Byte address within the chip-select window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| slot_id | input | 5 | Backplane slot number |
| sync_lost | input | 4 | Per-port loss-of-sync flag, 1 = port inactive |
| ts_en | input | 4 | Per-port framer timeslot-enable pin state |
| nt_mode | input | 4 | Per-port line-mode select, 1 = network side |
| tclk | inout | 4 | Per-port clock/sync pin |

## Verification
The assertions assume that the status inputs (slot number, loss-of-sync flags, timeslot-enable states) stay steady across each read strobe, so that the value returned one cycle later matches what was sampled. They also assume that nothing outside the block drives a clock/sync pin while that port's line-mode select is high. The stimulus respects both assumptions. It changes the status inputs and the line-mode selects only in cycles without a strobe. Its own pin driver is enabled exactly on the ports whose select is low, and it is updated in the same step as the selects.

// File: rtl/csr_pkg.sv
package csr_pkg;
  // Register selector carried on address bits [SEL_LSB+1:SEL_LSB]
  typedef enum logic [1:0] {
    SEL_SLOT = 2'b00,
    SEL_PORT = 2'b01,
    SEL_TSEN = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  localparam int SEL_LSB = 2;
endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output csr_pkg::reg_sel_e sel,
  output logic              rd_en,
  output logic              wr_port_en
);
  import csr_pkg::*;

  // Only the selector field is decoded; everything else mirrors.
  assign sel        = reg_sel_e'(addr[SEL_LSB+1:SEL_LSB]);
  assign rd_en      = cs && !we;
  assign wr_port_en = cs && we && (sel == SEL_PORT);
endmodule

// File: rtl/csr_fix_reg.sv
module csr_fix_reg #(
  parameter int NPORT  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPORT-1:0]  fix_q
);
  always_ff @(posedge clk) begin
    if (rst)        fix_q <= '0;
    else if (wr_en) fix_q <= wdata[NPORT-1:0];
  end
endmodule

// File: rtl/csr_readback.sv
module csr_readback #(
  parameter int NPORT  = 4,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  csr_pkg::reg_sel_e sel,
  input  logic [SLOT_W-1:0] slot_id,
  input  logic [NPORT-1:0]  sync_lost,
  input  logic [NPORT-1:0]  fix_q,
  input  logic [NPORT-1:0]  ts_en,
  output logic [DATA_W-1:0] rdata
);
  import csr_pkg::*;

  localparam int SLOT_PAD = DATA_W - SLOT_W;
  localparam int PORT_PAD = DATA_W - 2 * NPORT;
  localparam int TSEN_PAD = DATA_W - NPORT;

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] port_word;

  generate
    if (PORT_PAD > 0) begin : g_port_pad
      assign port_word = {{PORT_PAD{1'b0}}, sync_lost, fix_q};
    end else begin : g_port_full
      assign port_word = {sync_lost, fix_q};
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_SLOT: rd_mux = {{SLOT_PAD{1'b0}}, slot_id};
      SEL_PORT: rd_mux = port_word;
      SEL_TSEN: rd_mux = {{TSEN_PAD{1'b0}}, ts_en};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R9
  property hold_rdata_p;
    @(posedge clk) disable iff (rst) !rd_en |=> $stable(rdata);
  endproperty
  rdata_hold_chk: assert property (hold_rdata_p);

  // R6
  property none_zero_p;
    @(posedge clk) disable iff (rst) (rd_en && sel == SEL_NONE) |=> (rdata == '0);
  endproperty
  none_reads_zero_chk: assert property (none_zero_p);
endmodule

// File: rtl/csr_tclk_pads.sv
module csr_tclk_pads #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] nt_mode,
  input  logic [NPORT-1:0] fix_q,
  inout  wire  [NPORT-1:0] tclk
);
  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_pad
      assign tclk[p] = nt_mode[p] ? fix_q[p] : 1'bz;

      // R8
      property drive_fix_p;
        @(posedge clk) disable iff (rst) nt_mode[p] |-> (tclk[p] == fix_q[p]);
      endproperty
      pad_drive_chk: assert property (drive_fix_p);
    end
  endgenerate
endmodule

// File: rtl/board_csr.sv
module board_csr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NPORT  = 4,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [SLOT_W-1:0] slot_id,
  input  logic [NPORT-1:0]  sync_lost,
  input  logic [NPORT-1:0]  ts_en,
  input  logic [NPORT-1:0]  nt_mode,
  inout  wire  [NPORT-1:0]  tclk
);
  import csr_pkg::*;

  reg_sel_e         sel;
  logic             rd_en;
  logic             wr_port_en;
  logic [NPORT-1:0] fix_q;

  csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs(cs), .we(we), .addr(addr),
    .sel(sel), .rd_en(rd_en), .wr_port_en(wr_port_en)
  );

  csr_fix_reg #(.NPORT(NPORT), .DATA_W(DATA_W)) u_fix (
    .clk(clk), .rst(rst), .wr_en(wr_port_en), .wdata(wdata), .fix_q(fix_q)
  );

  csr_readback #(.NPORT(NPORT), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_rb (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
    .slot_id(slot_id), .sync_lost(sync_lost), .fix_q(fix_q), .ts_en(ts_en),
    .rdata(rdata)
  );

  csr_tclk_pads #(.NPORT(NPORT)) u_pads (
    .clk(clk), .rst(rst), .nt_mode(nt_mode), .fix_q(fix_q), .tclk(tclk)
  );

  // R4
  property port_write_p;
    @(posedge clk) disable iff (rst)
      (cs && we && addr[SEL_LSB+1:SEL_LSB] == 2'b01) |=> (fix_q == $past(wdata[NPORT-1:0]));
  endproperty
  fix_load_chk: assert property (port_write_p);

  // R6
  property other_write_p;
    @(posedge clk) disable iff (rst)
      (cs && we && addr[SEL_LSB+1:SEL_LSB] != 2'b01) |=> $stable(fix_q);
  endproperty
  fix_keep_chk: assert property (other_write_p);

  // R2
  property slot_pad_p;
    @(posedge clk) disable iff (rst)
      (cs && !we && addr[SEL_LSB+1:SEL_LSB] == 2'b00) |=> (rdata[DATA_W-1:SLOT_W] == '0);
  endproperty
  slot_pad_chk: assert property (slot_pad_p);

  // R5
  property tsen_pad_p;
    @(posedge clk) disable iff (rst)
      (cs && !we && addr[SEL_LSB+1:SEL_LSB] == 2'b10) |=> (rdata[DATA_W-1:NPORT] == '0);
  endproperty
  tsen_pad_chk: assert property (tsen_pad_p);
endmodule

// File: tb/sim_board_csr.sv
`timescale 1ns/1ps
module sim_board_csr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [4:0] slot_id = '0;
  logic [3:0] sync_lost = '0, ts_en = '0, nt_mode = '0;
  logic [3:0] tb_drv = '1, tb_val = '0;
  wire  [3:0] tclk;

  int errors = 0, checks = 0;
  logic [3:0] fix_m = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < 4; i++) begin : g_ext
    assign tclk[i] = tb_drv[i] ? tb_val[i] : 1'bz;
  end

  board_csr u0 (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .slot_id(slot_id), .sync_lost(sync_lost), .ts_en(ts_en),
    .nt_mode(nt_mode), .tclk(tclk)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard one half-cycle after the capturing edge
  always @(negedge clk) begin
    if (pend) begin
      pend = 1'b0;
      check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  function automatic logic [7:0] model(input logic [7:0] a);
    case (a[3:2])
      2'b00:   return {3'b000, slot_id};
      2'b01:   return {sync_lost, fix_m};
      2'b10:   return {4'b0000, ts_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_read(input logic [7:0] a, input string tag);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    @(posedge clk);
    pend = 1'b1;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    if (a[3:2] == 2'b01) fix_m = d[3:0];
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] m, input logic [3:0] v);
    @(negedge clk);
    nt_mode = m; tb_drv = ~m; tb_val = v;
  endtask

  task automatic check_pins(input string tag);
    @(negedge clk);
    for (int i = 0; i < 4; i++)
      check(tag, {7'b0, tclk[i]}, {7'b0, nt_mode[i] ? fix_m[i] : tb_val[i]});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    slot_id = 5'h15; sync_lost = 4'hA; ts_en = 4'h6; tb_val = 4'h5;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state of rdata, pins released
    check("R1 rdata", rdata, 8'h00);
    check_pins("R1 pins");
    do_read(8'h04, "R1 fix zero");

    do_read(8'h00, "R2 slot");
    slot_id = 5'h0B;
    do_read(8'h00, "R2 slot alt");
    do_read(8'h04, "R3 port");
    do_write(8'h04, 8'hF9);
    do_read(8'h04, "R4 write low nibble");
    do_read(8'h08, "R5 tsen");
    ts_en = 4'h9;
    do_read(8'h08, "R5 tsen alt");
    do_read(8'h0C, "R6 unused read");
    do_write(8'h00, 8'h0F);
    do_write(8'h08, 8'h06);
    do_write(8'h0C, 8'h00);
    do_read(8'h04, "R6 ro writes ignored");
    // R7: mirrored addresses
    do_write(8'hF7, 8'h03);
    do_read(8'h04, "R7 mirrored write");
    do_read(8'h83, "R7 mirror slot");
    do_read(8'h36, "R7 mirror port");
    do_read(8'hEA, "R7 mirror tsen");
    // R9: rdata holds across idle and write cycles
    sync_lost = 4'h3;
    do_write(8'h04, 8'h0C);
    @(negedge clk);
    check("R9 hold", rdata, {4'b0000, 4'h9});
    do_read(8'h04, "R3 port after change");
    // R8: pin direction per line mode
    set_mode(4'b0101, 4'b1010);
    check_pins("R8 mixed");
    do_write(8'h04, 8'h05);
    check_pins("R8 fix change");
    set_mode(4'b1111, 4'b0000);
    check_pins("R8 all nt");
    set_mode(4'b0000, 4'b0110);
    check_pins("R8 all te");
    // R1: reset again clears fix
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    fix_m = '0;
    check("R1 rdata re-reset", rdata, 8'h00);
    do_read(8'h04, "R1 fix after reset");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule